// File: doc/BRIEF.md
# Strobed Four-Digit Seven-Segment Latch

This block sits between a multiplexed counter or converter and a four-digit seven-segment display. The source presents one 4-bit binary or BCD character at a time on a shared data bus and raises one digit strobe per character. Each digit has its own strobe line. The block turns the bus value into a seven-segment pattern and holds that pattern in the register of the strobed digit, so all four digits stay lit between updates.

The strobes and the data come from an asynchronous source. Both pass through a synchroniser in the block clock domain. A character is committed when its strobe ends, which is the falling edge of the active-high strobe. The data committed is the value sampled while the strobe was still high. A build-time parameter selects one of two glyph sets. The first is full hexadecimal. The second shows the decimal digits and then, for codes 10 to 15, a dash, E, H, L, P and a blank. Backplane drive and the analog output stages belong elsewhere.

Top module: `mux_digit_latch`

## Requirements
- R1: While reset is applied and after it is released, every digit register holds the blank pattern (all 28 segment bits 0) until the first strobe completes.
- R2: `data_i` is true binary with bit 0 least significant. In hexadecimal mode, codes 0 to 15 show 0-9, A, b, C, d, E, F. Segment bit 0 is a, bits 1 to 5 are b to f, and bit 6 is g (the middle bar). A segment bit is 1 when the segment is on. The 6 includes the top bar a, the 7 omits f, and the 9 includes the bottom bar d.
- R3: In Code B mode, code 10 shows a dash (g only), 11 shows E, 12 shows H, 13 shows L, 14 shows P, and 15 shows a blank with all segments off.
- R4: Codes 0 to 9 produce identical patterns in both modes.
- R5: Strobe bit i (bit 0 for the least significant digit) writes only digit i. Digit i occupies `seg_o[7*i+6:7*i]`. The other digits keep their patterns.
- R6: A character is committed at the end of its strobe. While the strobe stays high, the output does not change. The new pattern appears no more than SYNC_STAGES+2 clocks after the strobe is first sampled low.
- R7: A change on `data_i` while no strobe is active leaves every digit unchanged.
- R8: When several strobes end together, every digit they select receives the same character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 4 | Character code, binary or BCD |
| strb_i | input | 4 | Active-high digit strobes, bit 0 = least significant digit |
| seg_o | output | 28 | Segment-on vector, 7 bits per digit |

## Verification
Every one of the 16 codes is written to each of the four digit positions in turn. One instance runs in each glyph mode, so the sweep separates the digit glyphs that the two sets share from the six codes where they differ. It also confirms that a strobe on one lane leaves the three other digits untouched. Separate patterns follow. A long strobe is checked with the output frozen until the strobe falls. Data wiggles with no strobe active. Strobes of several lanes end together.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int SEG_W  = 7;
    localparam int CODE_W = 4;

    typedef logic [SEG_W-1:0]  seg7_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        GLYPH_HEX   = 1'b0,
        GLYPH_CODEB = 1'b1
    } glyph_set_e;

    localparam seg7_t SEG_BLANK = '0;

    // bit 0 = a ... bit 6 = g
    function automatic seg7_t hex_glyph(input code_t c);
        seg7_t s;
        case (c)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

    function automatic seg7_t codeb_glyph(input code_t c);
        seg7_t s;
        case (c)
            4'hA: s = 7'h40;
            4'hB: s = 7'h79;
            4'hC: s = 7'h76;
            4'hD: s = 7'h38;
            4'hE: s = 7'h73;
            4'hF: s = SEG_BLANK;
            default: s = hex_glyph(c);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int LANES  = 4,
    parameter int STAGES = 2,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  strb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [LANES-1:0]  fall_o,
    output logic [DATA_W-1:0] data_o
);
    logic [STAGES-1:0][LANES-1:0]  sync_q;
    logic [STAGES:0][DATA_W-1:0]   data_q;
    logic [LANES-1:0]              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[g] <= '0;
                    data_q[g] <= '0;
                end else begin
                    sync_q[g] <= strb_i;
                    data_q[g] <= data_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[g] <= '0;
                    data_q[g] <= '0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                    data_q[g] <= data_q[g-1];
                end
            end
        end
    end

    // extra stage keeps data aligned with the last high strobe sample
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q         <= '0;
            data_q[STAGES] <= '0;
        end else begin
            prev_q         <= sync_q[STAGES-1];
            data_q[STAGES] <= data_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
    assign data_o = data_q[STAGES];
endmodule

// File: rtl/glyph_decoder.sv
module glyph_decoder
    import disp_pkg::*;
#(
    parameter glyph_set_e GLYPH_SET = GLYPH_HEX
) (
    input  code_t code_i,
    output seg7_t glyph_o
);
    if (GLYPH_SET == GLYPH_CODEB) begin : g_codeb
        assign glyph_o = codeb_glyph(code_i);
    end else begin : g_hex
        assign glyph_o = hex_glyph(code_i);
    end
endmodule

// File: rtl/digit_store.sv
module digit_store
    import disp_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIGITS-1:0] wr_en,
    input  seg7_t             glyph_i,
    output seg7_t [DIGITS-1:0] digits_o
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst)           digits_o[i] <= SEG_BLANK;
            else if (wr_en[i]) digits_o[i] <= glyph_i;
        end
    end
endmodule

// File: rtl/mux_digit_latch.sv
module mux_digit_latch
    import disp_pkg::*;
#(
    parameter int         NUM_DIGITS  = 4,
    parameter int         SYNC_STAGES = 2,
    parameter glyph_set_e GLYPH_SET   = GLYPH_HEX,
    localparam int        OUT_W       = NUM_DIGITS * SEG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CODE_W-1:0]     data_i,
    input  logic [NUM_DIGITS-1:0] strb_i,
    output logic [OUT_W-1:0]      seg_o
);
    logic [NUM_DIGITS-1:0]     wr_en;
    code_t                     code_s;
    seg7_t                     glyph;
    seg7_t [NUM_DIGITS-1:0]    digits;

    strobe_sync #(
        .LANES (NUM_DIGITS),
        .STAGES(SYNC_STAGES),
        .DATA_W(CODE_W)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .strb_i(strb_i),
        .data_i(data_i),
        .fall_o(wr_en),
        .data_o(code_s)
    );

    glyph_decoder #(.GLYPH_SET(GLYPH_SET)) u_dec (
        .code_i (code_s),
        .glyph_o(glyph)
    );

    digit_store #(.DIGITS(NUM_DIGITS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .glyph_i (glyph),
        .digits_o(digits)
    );

    assign seg_o = digits;
endmodule

// File: rtl/mux_digit_latch_chk.sv
module mux_digit_latch_chk #(
    parameter int NUM_DIGITS  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SEG_W       = 7
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_DIGITS-1:0]       strb_i,
    input logic [NUM_DIGITS-1:0]       wr_en,
    input logic [SEG_W-1:0]            glyph,
    input logic [NUM_DIGITS*SEG_W-1:0] seg_o
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: one edge after reset every digit is blank
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_blank_r1: assert (seg_o == '0)
                else $error("reset left segments lit");
        end
    end

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_lane
        // R5: a commit on lane i loads the decoded glyph into digit i
        p_commit_r5: assert property (@(posedge clk) disable iff (rst)
            wr_en[i] |=> seg_o[i*SEG_W +: SEG_W] == $past(glyph));
        // R7: without a commit the digit keeps its pattern
        p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
            !wr_en[i] |=> $stable(seg_o[i*SEG_W +: SEG_W]));
        // R6: a commit only follows a strobe sampled low
        p_end_only_r6: assert property (@(posedge clk) disable iff (rst)
            wr_en[i] |-> !$past(strb_i[i], SYNC_STAGES));
    end
endmodule

bind mux_digit_latch mux_digit_latch_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .SYNC_STAGES(SYNC_STAGES),
    .SEG_W      (disp_pkg::SEG_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .strb_i(strb_i),
    .wr_en (wr_en),
    .glyph (glyph),
    .seg_o (seg_o)
);

// File: tb/sim_mux_digit_latch.sv
module sim_mux_digit_latch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  data_i = '0;
    logic [3:0]  strb_i = '0;
    logic [27:0] seg_hex;
    logic [27:0] seg_cb;
    logic [6:0]  exp_hex [4];
    logic [6:0]  exp_cb  [4];
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    mux_digit_latch #(.GLYPH_SET(disp_pkg::GLYPH_HEX)) u0 (
        .clk(clk), .rst(rst), .data_i(data_i), .strb_i(strb_i), .seg_o(seg_hex));
    mux_digit_latch #(.GLYPH_SET(disp_pkg::GLYPH_CODEB)) u1 (
        .clk(clk), .rst(rst), .data_i(data_i), .strb_i(strb_i), .seg_o(seg_cb));

    function automatic logic [6:0] from_letters(input string s);
        logic [6:0] v = '0;
        for (int k = 0; k < s.len(); k++) v[s[k] - "a"] = 1'b1;
        return v;
    endfunction

    function automatic string hex_letters(input int c);
        case (c)
            0: return "abcdef";   1: return "bc";      2: return "abdeg";
            3: return "abcdg";    4: return "bcfg";    5: return "acdfg";
            6: return "acdefg";   7: return "abc";     8: return "abcdefg";
            9: return "abcdfg";   10: return "abcefg"; 11: return "cdefg";
            12: return "adef";    13: return "bcdeg";  14: return "adefg";
            default: return "aefg";
        endcase
    endfunction

    function automatic string codeb_letters(input int c);
        case (c)
            10: return "g";      11: return "adefg";  12: return "bcefg";
            13: return "def";    14: return "abefg";  15: return "";
            default: return hex_letters(c);
        endcase
    endfunction

    task automatic check(input string req, input logic [27:0] got, input logic [27:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [27:0] pack(input logic [6:0] d [4]);
        return {d[3], d[2], d[1], d[0]};
    endfunction

    task automatic check_all(input string req);
        check({req, " hex"}, seg_hex, pack(exp_hex));
        check({req, " codeB"}, seg_cb, pack(exp_cb));
    endtask

    task automatic write(input logic [3:0] mask, input int code);
        @(negedge clk); data_i = 4'(code);
        @(negedge clk); strb_i = mask;
        repeat (3) @(negedge clk);
        strb_i = '0;
        repeat (2) @(negedge clk);
        data_i = ~data_i;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) if (mask[i]) begin
            exp_hex[i] = from_letters(hex_letters(code));
            exp_cb[i]  = from_letters(codeb_letters(code));
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin exp_hex[i] = '0; exp_cb[i] = '0; end
        repeat (3) @(negedge clk);
        check_all("R1 during reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 after reset");

        // R2 R3 R4 R5: every code into every digit, neighbours untouched
        for (int d = 0; d < 4; d++) begin
            for (int c = 0; c < 16; c++) begin
                write(4'b0001 << d, c);
                check_all(c < 10 ? "R2 R4 R5 sweep" : "R2 R3 R5 sweep");
            end
        end

        // R6: held strobe does not update; commit after it ends
        write(4'b1111, 8);
        check_all("R8 all lanes");
        @(negedge clk); data_i = 4'd1;
        @(negedge clk); strb_i = 4'b0100;
        repeat (10) @(negedge clk);
        check_all("R6 held high");
        strb_i = '0;
        @(negedge clk);
        check_all("R6 just after fall");
        repeat (4) @(negedge clk);
        exp_hex[2] = from_letters(hex_letters(1));
        exp_cb[2]  = from_letters(codeb_letters(1));
        check_all("R6 after fall");

        // R7: data activity with no strobe
        for (int c = 0; c < 16; c++) begin
            @(negedge clk); data_i = 4'(c);
        end
        repeat (6) @(negedge clk);
        check_all("R7 no strobe");

        // R8: two lanes at once
        write(4'b0101, 13);
        check_all("R8 two lanes");
        write(4'b1010, 10);
        check_all("R8 other lanes");

        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 4; i++) begin exp_hex[i] = '0; exp_cb[i] = '0; end
        check_all("R1 re-reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule